// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides when a small microcontroller core goes to sleep, which clock domains stop while it sleeps, and how it comes back. Software writes an 8-bit control register with a mode code and an enable bit. The core then issues a one-cycle sleep strobe. If the enable bit is set and the mode code is legal, the block halts the core and gates the clock domains that the chosen mode names.

Each mode has its own set of wake sources. When one of them fires, the block turns the oscillator back on and counts a start-up delay that depends on the mode. It then restores all clock domains and holds the core halted for a fixed number of extra cycles before it releases it. An interrupt wake leaves the control register unchanged, so the core continues after its sleep instruction. A reset request that arrives during sleep follows the same timed path but clears the register. At the moment of release it raises a one-cycle flag that tells the core to start from its reset vector.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: Control register: bit 0 is the sleep enable and bits 3..1 are the mode code. Bits 7..4 ignore writes and read as 0. The whole register resets to 0x00, and `bus_rdata` always shows it.
- R2: A sleep strobe while awake with the enable bit at 1 and a legal mode code raises `core_halt` at the next clock edge. A strobe with the enable bit at 0 leaves `core_halt` low and every clock enabled.
- R3: Mode codes 100, 101 and 111 are reserved. A strobe with one of these codes and the enable bit at 1 leaves the block awake.
- R4: `clk_en` bits are 0 CPU, 1 I/O, 2 ADC and 3 asynchronous timer, and a 1 means running. While asleep they read: idle (000) 1110, ADC-noise-reduction (001) 1100, power-down (010) 0000, power-save (011) 1000, standby (110) 0000. While the core runs they read 1111.
- R5: `osc_en` stays 1 while asleep in idle, ADC-noise-reduction and standby, and goes to 0 in power-down and power-save. It returns to 1 at the wake edge.
- R6: Wake sources by mode. In idle and ADC-noise-reduction, `irq_pending`, `irq_ext_async` and `irq_tmr_async` all wake the block. In power-save only `irq_ext_async` and `irq_tmr_async` wake it. In power-down and standby only `irq_ext_async` wakes it. Any other interrupt input leaves the block asleep with its clocks gated.
- R7: If the wake source is sampled at edge w and the mode's start-up length is T, the clocks return to 1111 at edge w+T and `core_halt` falls at edge w+T+HALT_EXTRA (HALT_EXTRA defaults to 4).
- R8: T is T_SHORT for idle and ADC-noise-reduction, T_LONG for power-down and power-save, and T_STBY for standby. The mode is the one latched at sleep entry.
- R9: After an interrupt wake the control register keeps the value it held before sleep, and `resume_vec` stays 0.
- R10: A `core_rst_req` pulse during sleep wakes the block in every mode and clears the control register. The release follows the R7 timing, and `resume_vec` is 1 for exactly the one cycle in which `core_halt` first reads 0.
- R11: A `core_rst_req` pulse while awake clears the control register and leaves `core_halt` and `resume_vec` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Control register read value |
| sleep_strobe | input | 1 | One-cycle sleep-instruction strobe from the core |
| irq_pending | input | 1 | Any enabled interrupt is pending |
| irq_ext_async | input | 1 | Asynchronous external interrupt (already synchronised) |
| irq_tmr_async | input | 1 | Asynchronous timer interrupt (already synchronised) |
| core_rst_req | input | 1 | Reset event for the core |
| core_halt | output | 1 | Core is halted |
| clk_en | output | 4 | Per-domain clock enables |
| osc_en | output | 1 | Main oscillator enable |
| resume_vec | output | 1 | One-cycle flag at release: start from the reset vector |

## Verification
The hardest case to reach is a wake source that must be ignored while the block stays asleep. Seeing it needs the block in the right mode, with its clocks gated, and only the ports as evidence. The bench enters power-down and pulses the non-waking interrupts. It then checks over several cycles that the halt and clock gating stay in place, and finally wakes the block with the external input to show it was still asleep. Reset-during-sleep is reached the same way from standby. The bench counts halt and gated cycles sample by sample, so the R7 edges are checked exactly.

// File: rtl/sleep_pwr_pkg.sv
package sleep_pwr_pkg;

  localparam int CTRL_W = 8;
  localparam int N_DOM  = 4;

  localparam int DOM_CPU  = 0;
  localparam int DOM_IO   = 1;
  localparam int DOM_ADC  = 2;
  localparam int DOM_ATMR = 3;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'b000,
    MD_ADCNR = 3'b001,
    MD_PDOWN = 3'b010,
    MD_PSAVE = 3'b011,
    MD_STBY  = 3'b110
  } sleep_mode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_SLEEP,
    ST_WARM,
    ST_HOLD
  } pwr_state_e;

endpackage

// File: rtl/sleep_ctrl_reg.sv
module sleep_ctrl_reg
  import sleep_pwr_pkg::*;
#(
  parameter logic [CTRL_W-1:0] WR_MASK = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] rdata,
  output logic [2:0]        mode,
  output logic              enable
);

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= wdata & WR_MASK;
    end
  end

  assign rdata  = ctrl_q;
  assign mode   = ctrl_q[3:1];
  assign enable = ctrl_q[0];

endmodule

// File: rtl/sleep_mode_decode.sv
module sleep_mode_decode
  import sleep_pwr_pkg::*;
#(
  parameter int T_SHORT = 6,
  parameter int T_LONG  = 40,
  parameter int T_STBY  = 10,
  parameter int CNT_W   = 6
) (
  input  logic [2:0]       mode,
  output logic             valid,
  output logic [N_DOM-1:0] gate_en,
  output logic             osc_keep,
  output logic             wk_any,
  output logic             wk_ext,
  output logic             wk_tmr,
  output logic [CNT_W-1:0] start_m1
);

  always_comb begin
    valid    = 1'b1;
    gate_en  = '1;
    osc_keep = 1'b1;
    wk_any   = 1'b0;
    wk_ext   = 1'b1;
    wk_tmr   = 1'b0;
    start_m1 = CNT_W'(T_SHORT - 1);
    case (mode)
      MD_IDLE: begin
        gate_en[DOM_CPU] = 1'b0;
        wk_any = 1'b1;
        wk_tmr = 1'b1;
      end
      MD_ADCNR: begin
        gate_en[DOM_CPU] = 1'b0;
        gate_en[DOM_IO]  = 1'b0;
        wk_any = 1'b1;
        wk_tmr = 1'b1;
      end
      MD_PDOWN: begin
        gate_en  = '0;
        osc_keep = 1'b0;
        start_m1 = CNT_W'(T_LONG - 1);
      end
      MD_PSAVE: begin
        gate_en           = '0;
        gate_en[DOM_ATMR] = 1'b1;
        osc_keep          = 1'b0;
        wk_tmr            = 1'b1;
        start_m1          = CNT_W'(T_LONG - 1);
      end
      MD_STBY: begin
        gate_en  = '0;
        start_m1 = CNT_W'(T_STBY - 1);
      end
      default: begin
        valid = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/wake_delay_timer.sv
module wake_delay_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import sleep_pwr_pkg::*;
#(
  parameter int                T_SHORT    = 6,
  parameter int                T_LONG     = 40,
  parameter int                T_STBY     = 10,
  parameter int                HALT_EXTRA = 4,
  parameter logic [CTRL_W-1:0] WR_MASK    = 8'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              sleep_strobe,
  input  logic              irq_pending,
  input  logic              irq_ext_async,
  input  logic              irq_tmr_async,
  input  logic              core_rst_req,
  output logic              core_halt,
  output logic [N_DOM-1:0]  clk_en,
  output logic              osc_en,
  output logic              resume_vec
);

  localparam int T_MAX0 = (T_LONG > T_SHORT) ? T_LONG : T_SHORT;
  localparam int T_MAX1 = (T_STBY > T_MAX0) ? T_STBY : T_MAX0;
  localparam int T_MAX  = (HALT_EXTRA > T_MAX1) ? HALT_EXTRA : T_MAX1;
  localparam int CNT_W  = $clog2(T_MAX + 1);

  logic [2:0]       ctrl_mode;
  logic             ctrl_se;
  logic [2:0]       mode_q;
  logic [2:0]       dec_mode;
  logic             dec_valid;
  logic [N_DOM-1:0] dec_gate;
  logic             dec_osc;
  logic             dec_wk_any;
  logic             dec_wk_ext;
  logic             dec_wk_tmr;
  logic [CNT_W-1:0] dec_start_m1;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;
  logic             wake_hit;
  logic             enter_ok;
  logic             rst_wake_q;
  pwr_state_e       state_q;

  sleep_ctrl_reg #(.WR_MASK(WR_MASK)) u_reg (
    .clk   (clk),
    .rst   (rst),
    .clr   (core_rst_req),
    .wr_en (bus_wr_en),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .mode  (ctrl_mode),
    .enable(ctrl_se)
  );

  // While running, decode the requested mode; afterwards, the latched one.
  assign dec_mode = (state_q == ST_RUN) ? ctrl_mode : mode_q;

  sleep_mode_decode #(
    .T_SHORT(T_SHORT),
    .T_LONG (T_LONG),
    .T_STBY (T_STBY),
    .CNT_W  (CNT_W)
  ) u_dec (
    .mode    (dec_mode),
    .valid   (dec_valid),
    .gate_en (dec_gate),
    .osc_keep(dec_osc),
    .wk_any  (dec_wk_any),
    .wk_ext  (dec_wk_ext),
    .wk_tmr  (dec_wk_tmr),
    .start_m1(dec_start_m1)
  );

  assign wake_hit = (dec_wk_any & irq_pending) |
                    (dec_wk_ext & irq_ext_async) |
                    (dec_wk_tmr & irq_tmr_async) |
                    core_rst_req;

  assign enter_ok = sleep_strobe & ctrl_se & dec_valid & ~core_rst_req;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = dec_start_m1;
    if (state_q == ST_SLEEP && wake_hit) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_WARM && tmr_done) begin
      tmr_load = 1'b1;
      tmr_val  = CNT_W'(HALT_EXTRA - 1);
    end
  end

  wake_delay_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .done    (tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      mode_q     <= '0;
      core_halt  <= 1'b0;
      clk_en     <= '1;
      osc_en     <= 1'b1;
      resume_vec <= 1'b0;
      rst_wake_q <= 1'b0;
    end else begin
      resume_vec <= 1'b0;
      case (state_q)
        ST_RUN: begin
          if (enter_ok) begin
            state_q   <= ST_SLEEP;
            mode_q    <= ctrl_mode;
            core_halt <= 1'b1;
            clk_en    <= dec_gate;
            osc_en    <= dec_osc;
          end
        end
        ST_SLEEP: begin
          if (wake_hit) begin
            state_q    <= ST_WARM;
            osc_en     <= 1'b1;
            rst_wake_q <= core_rst_req;
          end
        end
        ST_WARM: begin
          if (core_rst_req) rst_wake_q <= 1'b1;
          if (tmr_done) begin
            state_q <= ST_HOLD;
            clk_en  <= '1;
          end
        end
        ST_HOLD: begin
          if (core_rst_req) rst_wake_q <= 1'b1;
          if (tmr_done) begin
            state_q    <= ST_RUN;
            core_halt  <= 1'b0;
            resume_vec <= rst_wake_q | core_rst_req;
            rst_wake_q <= 1'b0;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  // Halt may only begin on an enabled sleep strobe.
  assert_entry_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(core_halt) |-> $past(sleep_strobe && ctrl_se));

  // Reserved mode codes never lead to sleep.
  assert_reserved_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && sleep_strobe && ctrl_se &&
     (ctrl_mode == 3'b100 || ctrl_mode == 3'b101 || ctrl_mode == 3'b111))
    |=> !core_halt);

  // A running core always has every domain clocked and the oscillator on.
  assert_awake_clocks_R4: assert property (@(posedge clk) disable iff (rst)
    !core_halt |-> (&clk_en && osc_en));

  // Clocks are back at least one cycle before the core is released.
  assert_release_order_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(core_halt) |-> (&clk_en && $past(&clk_en)));

  // The reset-vector flag only accompanies a release.
  assert_resume_at_release_R10: assert property (@(posedge clk) disable iff (rst)
    resume_vec |-> $fell(core_halt));

endmodule

// File: tb/sleep_pwr_ctrl_bench.sv
module sleep_pwr_ctrl_bench;

  localparam int TS = 6;
  localparam int TL = 40;
  localparam int TB = 10;
  localparam int HX = 4;

  typedef struct packed {
    logic [2:0]  mode;
    logic        ok;
    logic [3:0]  gate;
    logic        osc;
    logic [15:0] tlen;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'b000, 1'b1, 4'b1110, 1'b1, 16'(TS)},
    '{3'b001, 1'b1, 4'b1100, 1'b1, 16'(TS)},
    '{3'b010, 1'b1, 4'b0000, 1'b0, 16'(TL)},
    '{3'b011, 1'b1, 4'b1000, 1'b0, 16'(TL)},
    '{3'b100, 1'b0, 4'b1111, 1'b1, 16'(0)},
    '{3'b101, 1'b0, 4'b1111, 1'b1, 16'(0)},
    '{3'b110, 1'b1, 4'b0000, 1'b1, 16'(TB)},
    '{3'b111, 1'b0, 4'b1111, 1'b1, 16'(0)}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sleep_strobe = 1'b0;
  logic       irq_pending = 1'b0;
  logic       irq_ext_async = 1'b0;
  logic       irq_tmr_async = 1'b0;
  logic       core_rst_req = 1'b0;
  logic       core_halt;
  logic [3:0] clk_en;
  logic       osc_en;
  logic       resume_vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  sleep_pwr_ctrl #(
    .T_SHORT(TS), .T_LONG(TL), .T_STBY(TB), .HALT_EXTRA(HX), .WR_MASK(8'h0F)
  ) u_sleep_pwr_ctrl (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sleep_strobe(sleep_strobe), .irq_pending(irq_pending),
    .irq_ext_async(irq_ext_async), .irq_tmr_async(irq_tmr_async),
    .core_rst_req(core_rst_req), .core_halt(core_halt), .clk_en(clk_en),
    .osc_en(osc_en), .resume_vec(resume_vec)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] v);
    @(negedge clk); bus_wr_en = 1'b1; bus_wdata = v;
    @(negedge clk); bus_wr_en = 1'b0;
  endtask

  task automatic do_strobe();
    @(negedge clk); sleep_strobe = 1'b1;
    @(negedge clk); sleep_strobe = 1'b0;
  endtask

  // Pulse the chosen sources for one cycle, then count halted and gated samples.
  task automatic wake_count(input logic any_i, input logic ext_i, input logic tmr_i,
                            input logic rst_i, output int nh, output int ng,
                            output logic vec_mid, output logic vec_rel,
                            output logic vec_after);
    int guard;
    @(negedge clk);
    irq_pending = any_i; irq_ext_async = ext_i; irq_tmr_async = tmr_i; core_rst_req = rst_i;
    @(negedge clk);
    irq_pending = 1'b0; irq_ext_async = 1'b0; irq_tmr_async = 1'b0; core_rst_req = 1'b0;
    nh = 0; ng = 0; vec_mid = 1'b0; guard = 0;
    while (core_halt === 1'b1 && guard < 1000) begin
      nh++;
      if (clk_en !== 4'hF) ng++;
      if (resume_vec === 1'b1) vec_mid = 1'b1;
      guard++;
      @(negedge clk);
    end
    vec_rel = resume_vec;
    @(negedge clk);
    vec_after = resume_vec;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nh, ng;
    logic vm, vr, va;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // Reset state
    chk("R1", "reset rdata", bus_rdata, 8'h00);
    chk("R4", "reset clk_en", clk_en, 4'hF);
    chk("R5", "reset osc_en", osc_en, 1'b1);
    chk("R2", "reset halt", core_halt, 1'b0);
    chk("R10", "reset resume_vec", resume_vec, 1'b0);

    // Table walk over every mode code
    for (int i = 0; i < 8; i++) begin
      wr_reg({4'b0, VEC[i].mode, 1'b1});
      do_strobe();
      chk(VEC[i].ok ? "R2" : "R3", $sformatf("halt mode %0d", i), core_halt, VEC[i].ok);
      chk("R4", $sformatf("clk_en mode %0d", i), clk_en, VEC[i].gate);
      chk("R5", $sformatf("osc_en mode %0d", i), osc_en, VEC[i].osc);
      if (VEC[i].ok) begin
        wake_count(1'b0, 1'b1, 1'b0, 1'b0, nh, ng, vm, vr, va);
        chk("R7", $sformatf("halt cycles mode %0d", i), nh, VEC[i].tlen + HX);
        chk("R8", $sformatf("gated cycles mode %0d", i), ng, VEC[i].tlen);
        chk("R9", $sformatf("no resume_vec mode %0d", i), {vm, vr, va}, 3'b000);
        chk("R9", $sformatf("reg kept mode %0d", i), bus_rdata, {4'b0, VEC[i].mode, 1'b1});
      end
    end

    // R1: reserved bits ignore writes
    wr_reg(8'hFF);
    chk("R1", "masked write", bus_rdata, 8'h0F);

    // R2: strobe with enable clear
    wr_reg(8'h00);
    do_strobe();
    chk("R2", "disabled strobe halt", core_halt, 1'b0);
    chk("R2", "disabled strobe clocks", clk_en, 4'hF);

    // R6: power-down ignores pending and timer interrupts
    wr_reg(8'h05);
    do_strobe();
    @(negedge clk); irq_pending = 1'b1; irq_tmr_async = 1'b1;
    @(negedge clk); irq_pending = 1'b0; irq_tmr_async = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6", "pdown stays asleep", core_halt, 1'b1);
    chk("R6", "pdown clocks gated", clk_en, 4'h0);
    chk("R6", "pdown osc off", osc_en, 1'b0);
    wake_count(1'b0, 1'b1, 1'b0, 1'b0, nh, ng, vm, vr, va);
    chk("R6", "pdown ext wake halt cycles", nh, TL + HX);

    // R6: power-save woken by the timer interrupt
    wr_reg(8'h07);
    do_strobe();
    wake_count(1'b0, 1'b0, 1'b1, 1'b0, nh, ng, vm, vr, va);
    chk("R6", "psave timer wake halt cycles", nh, TL + HX);

    // R6: idle woken by a pending interrupt
    wr_reg(8'h01);
    do_strobe();
    wake_count(1'b1, 1'b0, 1'b0, 1'b0, nh, ng, vm, vr, va);
    chk("R6", "idle pending wake halt cycles", nh, TS + HX);

    // R10: reset during standby
    wr_reg(8'h0D);
    do_strobe();
    chk("R10", "standby entered", core_halt, 1'b1);
    wake_count(1'b0, 1'b0, 1'b0, 1'b1, nh, ng, vm, vr, va);
    chk("R10", "reset wake halt cycles", nh, TB + HX);
    chk("R10", "resume_vec at release only", {vm, vr, va}, 3'b010);
    chk("R10", "reg cleared by reset wake", bus_rdata, 8'h00);

    // R11: reset while awake
    wr_reg(8'h03);
    @(negedge clk); core_rst_req = 1'b1;
    @(negedge clk); core_rst_req = 1'b0;
    chk("R11", "awake reset clears reg", bus_rdata, 8'h00);
    chk("R11", "awake reset no halt", core_halt, 1'b0);
    chk("R11", "awake reset no resume_vec", resume_vec, 1'b0);

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule